// File: doc/BRIEF.md
# Coprocessor ALU with Condition Flags

This block is the arithmetic and logic unit of a small RISC coprocessor whose instructions are all 16 bits wide. It computes ADD, SUB, AND, OR and XOR in two forms. The triadic form takes two full 16-bit register operands. The immediate form combines one byte lane of the destination register with an 8-bit constant and passes the other lane through unchanged.

The unit keeps a four-bit condition register made of sign (N), zero (Z), signed overflow (V) and carry/borrow (C). Arithmetic updates all four flags. Logic operations update N, Z and V and leave C as it was. A transfer operation copies the condition register into the low byte of the destination value.

The result and its write enable are combinational from the inputs and the current flags. The flags themselves are registered. Instruction fetch, decode and the register file sit outside this block. The decoder supplies the operation code, the form, the lane select, the current destination value, both source values and the immediate.

Top module: `cop_alu`

## Requirements
- R1: In triadic form (`imm_form_i`=0), `result_o` = `rs1_i` op `rs2_i` on 16 bits. The `op_i` codes are 3'b000 ADD, 3'b001 SUB (rs1 minus rs2), 3'b010 AND, 3'b011 OR and 3'b100 XOR.
- R2: For ADD and SUB, the new N is the result's top bit and Z is set when the result is zero. V is set on two's-complement overflow. C is the carry out for ADD and the borrow for SUB, so C=1 when unsigned rs1 < rs2.
- R3: For AND, OR and XOR, N and Z follow the result and V is cleared to 0. C keeps its previous value.
- R4: In immediate form with `hi_lane_i`=1, `result_o[15:8]` = `rd_i[15:8]` op `imm_i` and `result_o[7:0]` = `rd_i[7:0]`. The flags come from the 8-bit lane, with N taken from lane bit 7 and carry or borrow taken out of bit 7.
- R5: In immediate form with `hi_lane_i`=0, `result_o[7:0]` = `rd_i[7:0]` op `imm_i` and `result_o[15:8]` = `rd_i[15:8]`. The flags come from the 8-bit lane in the same way as in R4.
- R6: `op_i` 3'b101 (transfer) gives `result_o` = {12'h000, current flags} with `wr_en_o`=1 and does not change the flags. The form and lane inputs have no effect on it.
- R7: `flags_o` is {N,Z,V,C} in bits 3..0. It takes the new value on a rising clock edge only when `valid_i`=1 and `op_i` is one of ADD to XOR. Otherwise it holds.
- R8: While `rst_ni` is low, `flags_o` is 4'b0000. `wr_en_o` is 0 whenever `valid_i` is 0.
- R9: Codes 3'b110 and 3'b111 are reserved. They give `result_o`=0 and `wr_en_o`=0 and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation valid this cycle |
| op_i | input | 3 | Operation code |
| imm_form_i | input | 1 | 1 = byte-lane immediate form |
| hi_lane_i | input | 1 | Immediate lane: 1 = high byte, 0 = low byte |
| rd_i | input | 16 | Current destination register value |
| rs1_i | input | 16 | First source operand |
| rs2_i | input | 16 | Second source operand |
| imm_i | input | 8 | Immediate constant |
| result_o | output | 16 | Value to write to the destination |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Condition flags {N,Z,V,C} |

## Verification
A wrong result path shows on `result_o` in the same cycle the operation is presented. The bench checks it there, one time unit after it drives the inputs. A corrupted flag state, for example a C bit disturbed by a logic operation or an update made on an idle cycle, shows on `flags_o` right after the next rising edge. It also reaches `result_o` through a later transfer operation. Because the flag state carries across operations, a single bad update can cause mismatches on several later operations. The bench therefore compares against its own running flag model after every edge, so the first divergence is reported at the edge where it happened.

// File: rtl/cop_alu_pkg.sv
package cop_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_XFER = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } alu_op_e;

  localparam int unsigned FLAG_W = 4;
  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAG_V = 1;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_N = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

  function automatic logic op_writes_flags(alu_op_e op);
    return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR};
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return op inside {OP_AND, OP_OR, OP_XOR};
  endfunction
endpackage

// File: rtl/cop_alu_unit.sv
module cop_alu_unit
  import cop_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           c_prev_i,
  output logic [W-1:0]   res_o,
  output alu_flags_t     flags_o
);
  localparam int unsigned MSB = W - 1;

  logic [W:0] sum_w, dif_w;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    res_o     = '0;
    flags_o.c = c_prev_i;
    flags_o.v = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        res_o     = sum_w[W-1:0];
        flags_o.c = sum_w[W];
        flags_o.v = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
      end
      OP_SUB: begin
        res_o     = dif_w[W-1:0];
        flags_o.c = dif_w[W];  // borrow
        flags_o.v = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);
      end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
    flags_o.n = res_o[MSB];
    flags_o.z = (res_o == '0);
  end
endmodule

// File: rtl/cop_alu_flags.sv
module cop_alu_flags
  import cop_alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R8: flags clear while in reset
  a_r8_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);

  // R7: no write, no change
  a_r7_hold_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/cop_alu.sv
module cop_alu
  import cop_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic              imm_form_i,
  input  logic              hi_lane_i,
  input  logic [DATA_W-1:0] rd_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [DATA_W/2-1:0] imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o
);
  localparam int unsigned LANE_W = DATA_W / 2;

  alu_op_e      op;
  alu_flags_t   flags_q, full_fl, lane_fl, next_fl;
  logic [DATA_W-1:0] full_res;
  logic [LANE_W-1:0] lane_a, lane_res;
  logic         flag_we;

  assign op = alu_op_e'(op_i);

  // Full-width unit for the triadic form
  cop_alu_unit #(.W(DATA_W)) u_full (
    .op_i     (op),
    .a_i      (rs1_i),
    .b_i      (rs2_i),
    .c_prev_i (flags_q.c),
    .res_o    (full_res),
    .flags_o  (full_fl)
  );

  assign lane_a = hi_lane_i ? rd_i[DATA_W-1:LANE_W] : rd_i[LANE_W-1:0];

  // Byte-lane unit for the immediate form
  cop_alu_unit #(.W(LANE_W)) u_lane (
    .op_i     (op),
    .a_i      (lane_a),
    .b_i      (imm_i),
    .c_prev_i (flags_q.c),
    .res_o    (lane_res),
    .flags_o  (lane_fl)
  );

  always_comb begin
    result_o = '0;
    if (op == OP_XFER) begin
      result_o = {{(DATA_W-FLAG_W){1'b0}}, flags_q};
    end else if (op_writes_flags(op)) begin
      if (!imm_form_i)    result_o = full_res;
      else if (hi_lane_i) result_o = {lane_res, rd_i[LANE_W-1:0]};
      else                result_o = {rd_i[DATA_W-1:LANE_W], lane_res};
    end
  end

  assign next_fl = imm_form_i ? lane_fl : full_fl;
  assign flag_we = valid_i && op_writes_flags(op);
  assign wr_en_o = valid_i && (op_writes_flags(op) || op == OP_XFER);

  cop_alu_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we),
    .d_i    (next_fl),
    .q_o    (flags_q)
  );

  assign flags_o = flags_q;

  // R3: logic ops keep carry
  a_r3_carry_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_is_logic(op) |=> flags_o[FLAG_C] == $past(flags_o[FLAG_C]));

  // R3: logic ops clear overflow
  a_r3_v_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_is_logic(op) |=> !flags_o[FLAG_V]);

  // R6: transfer leaves flags alone
  a_r6_xfer_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_XFER |=> $stable(flags_o));

  // R4: high-lane immediate keeps low byte
  a_r4_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_form_i && hi_lane_i && op_writes_flags(op) |->
      result_o[LANE_W-1:0] == rd_i[LANE_W-1:0]);

  // R5: low-lane immediate keeps high byte
  a_r5_high_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_form_i && !hi_lane_i && op_writes_flags(op) |->
      result_o[DATA_W-1:LANE_W] == rd_i[DATA_W-1:LANE_W]);

  // R8: idle means no write
  a_r8_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !wr_en_o);

  // R9: reserved codes write nothing and hold flags
  a_r9_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[2:1] == 2'b11 |=> $stable(flags_o));
endmodule

// File: tb/cop_alu_tb_top.sv
`timescale 1ns/1ps
module cop_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        imm_form_i = 1'b0;
  logic        hi_lane_i = 1'b0;
  logic [15:0] rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic [7:0]  imm_i = '0;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails = 0;
  logic [3:0] model_fl = 4'h0;

  always #2.5 clk_i = ~clk_i;

  cop_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .imm_form_i(imm_form_i), .hi_lane_i(hi_lane_i), .rd_i(rd_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic imm, input logic hi,
                       input logic [15:0] rd, input logic [15:0] a16, input logic [15:0] b16,
                       input logic [7:0] i8, input logic [3:0] fl,
                       output logic [15:0] res, output logic wr, output logic upd,
                       output logic [3:0] nf);
    longint w, a, b, r, sa, sb, sr, full;
    logic n, z, v, c;
    w = imm ? 8 : 16;
    full = (longint'(1) << w);
    a = imm ? (hi ? longint'(rd[15:8]) : longint'(rd[7:0])) : longint'(a16);
    b = imm ? longint'(i8) : longint'(b16);
    sa = (a >= full/2) ? a - full : a;
    sb = (b >= full/2) ? b - full : b;
    c = fl[0]; v = 1'b0; r = 0;
    res = 16'h0; wr = 1'b0; upd = 1'b0; nf = fl;
    case (op)
      3'd0: begin r = a + b; sr = sa + sb; c = (r >= full);
                  v = (sr >= full/2) || (sr < -(full/2)); end
      3'd1: begin r = a - b; sr = sa - sb; c = (a < b);
                  v = (sr >= full/2) || (sr < -(full/2)); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      default: ;
    endcase
    r = r & (full - 1);
    if (op <= 3'd4) begin
      n = ((r >> (w - 1)) & 1) != 0;
      z = (r == 0);
      nf = {n, z, v, c};
      wr = 1'b1; upd = 1'b1;
      if (!imm) res = r[15:0];
      else if (hi) res = {r[7:0], rd[7:0]};
      else res = {rd[15:8], r[7:0]};
    end else if (op == 3'd5) begin
      res = {12'h0, fl}; wr = 1'b1;
    end
  endtask

  task automatic run_op(input string req, input logic vld, input logic [2:0] op,
                        input logic imm, input logic hi, input logic [15:0] rd,
                        input logic [15:0] a16, input logic [15:0] b16, input logic [7:0] i8);
    logic [15:0] er; logic ew, eu; logic [3:0] ef;
    @(negedge clk_i);
    valid_i = vld; op_i = op; imm_form_i = imm; hi_lane_i = hi;
    rd_i = rd; rs1_i = a16; rs2_i = b16; imm_i = i8;
    model(op, imm, hi, rd, a16, b16, i8, model_fl, er, ew, eu, ef);
    #1;
    chk({req, " result"}, result_o, er);
    chk({req, " wr_en"}, {15'h0, wr_en_o}, {15'h0, ew && vld});
    if (vld && eu) model_fl = ef;
    @(posedge clk_i); #1;
    chk({req, " flags"}, {12'h0, flags_o}, {12'h0, model_fl});
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    #12;
    chk("R8 reset flags", {12'h0, flags_o}, 16'h0);
    rst_ni = 1'b1;
    // R8 idle no write
    run_op("R8 idle", 1'b0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h1, 16'h2, 8'h0);
    // R1/R2 add overflow 0x7FFF+1
    run_op("R2 add ovf", 1'b1, 3'd0, 1'b0, 1'b0, 16'h0, 16'h7FFF, 16'h0001, 8'h0);
    run_op("R2 add carry zero", 1'b1, 3'd0, 1'b0, 1'b0, 16'h0, 16'hFFFF, 16'h0001, 8'h0);
    run_op("R2 sub borrow", 1'b1, 3'd1, 1'b0, 1'b0, 16'h0, 16'h0003, 16'h0005, 8'h0);
    // R3 carry kept (C=1 from borrow)
    run_op("R3 and keeps C", 1'b1, 3'd2, 1'b0, 1'b0, 16'h0, 16'hF0F0, 16'h0FF0, 8'h0);
    run_op("R3 xor zero", 1'b1, 3'd4, 1'b0, 1'b0, 16'h0, 16'hA5A5, 16'hA5A5, 8'h0);
    // R6 transfer
    run_op("R6 xfer", 1'b1, 3'd5, 1'b1, 1'b1, 16'hBEEF, 16'h0, 16'h0, 8'h0);
    // R4 high-lane AND with FE clears bit 8
    run_op("R4 and hi FE", 1'b1, 3'd2, 1'b1, 1'b1, 16'h0137, 16'h0, 16'h0, 8'hFE);
    // R5 low-lane increment
    run_op("R5 add lo inc", 1'b1, 3'd0, 1'b1, 1'b0, 16'h12FF, 16'h0, 16'h0, 8'h01);
    run_op("R5 add lo ovf", 1'b1, 3'd0, 1'b1, 1'b0, 16'h347F, 16'h0, 16'h0, 8'h01);
    run_op("R4 sub hi", 1'b1, 3'd1, 1'b1, 1'b1, 16'h0280, 16'h0, 16'h0, 8'h01);
    // R9 reserved
    run_op("R9 reserved6", 1'b1, 3'd6, 1'b0, 1'b0, 16'h0, 16'h1234, 16'h4321, 8'h0);
    run_op("R9 reserved7", 1'b1, 3'd7, 1'b1, 1'b1, 16'hFFFF, 16'h0, 16'h0, 8'hFF);
    run_op("R7 idle hold", 1'b0, 3'd1, 1'b0, 1'b0, 16'h0, 16'h0, 16'h1, 8'h0);
    run_op("R6 xfer2", 1'b1, 3'd5, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 8'h0);
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      run_op("R1 R7 random", ($urandom_range(0, 7) != 0), op, 1'($urandom),
             1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule